// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes, in a single accepted request, everything a small 32-bit RISC core with branch delay slots needs in order to enter an exception handler. The core presents an exception index together with its current PC, next PC, pending jump target, a delay-slot flag and the live status word. One cycle later the block presents, all at once, the following results:

- the return address to save;
- a copy of the old status word for the saved-status register;
- the rewritten supervisor-mode status word;
- the handler vector;
- a TLB-flush pulse and a translation-off pulse;
- a pulse that clears the core's delay-slot flag;
- an abort flag for indices that have no vector.

The request side is a valid/ready stream. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The request fields must stay stable while `req_valid` is high and `req_ready` is low. `req_ready` drops for exactly the one cycle in which a result is presented, so a held request is taken on the following edge. Results carry no back-pressure: `done` is a one-cycle pulse, and the data outputs hold their values until the next result.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The saved return PC `epc_o` depends on the exception class and on `req_dslot`.
  - Resume-after indices (5 tick, 8 external interrupt, 12 system call, 13 floating point) save `req_jmp_pc` when `req_dslot`=1 and `req_npc` when `req_dslot`=0.
  - Every other index re-executes: it saves `req_pc`-4 (modulo 2^32) when `req_dslot`=1 and `req_pc` when `req_dslot`=0.
- R2: `esr_o` equals the unmodified `req_sr` of the accepted request.
- R3: `sr_o` is built from `req_sr` as follows:
  - bit 0 (supervisor) is set;
  - bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) are cleared;
  - bit 13 (delay-slot exception) is set when `req_dslot`=1 and otherwise keeps its old value;
  - every other bit keeps its old value.
- R4: For an index in the range 1 to 14, `vec_take`=1, `abort`=0 and `vec_pc_o` = index << 8.
- R5: For index 0 or an index of 15 or above, `abort`=1, `vec_take`=0 and `vec_pc_o`=0. R1 to R3 still apply to such a request.
- R6: `done`, `tlb_flush` and `xlate_off` are high for exactly the one cycle after each accepted request, and are low at all other times.
- R7: `req_ready` is low in every cycle in which `done` is high and high otherwise. A request offered in that cycle is not taken: no `done` follows on the next cycle, and the outputs are unchanged.
- R8: `pend_idx` is all ones after reset. It shows the accepted index while `done` is high and returns to all ones on the next cycle.
- R9: `dslot_clr` is high together with `done` exactly when the accepted request had `req_dslot`=1.
- R10: During and right after reset, all pulses are low, `req_ready` is high and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_idx | input | 5 | Exception index |
| req_pc | input | 32 | PC of the faulting instruction |
| req_npc | input | 32 | Next sequential PC |
| req_jmp_pc | input | 32 | Pending jump target |
| req_dslot | input | 1 | Faulting instruction is in a delay slot |
| req_sr | input | 32 | Current status word |
| done | output | 1 | One-cycle result strobe |
| epc_o | output | 32 | Return address to save |
| esr_o | output | 32 | Status word to save |
| sr_o | output | 32 | New status word |
| vec_pc_o | output | 32 | Handler vector address |
| vec_take | output | 1 | Vector is valid and should be taken |
| abort | output | 1 | Index has no vector |
| tlb_flush | output | 1 | Flush address translation caches |
| xlate_off | output | 1 | Switch to untranslated addressing |
| dslot_clr | output | 1 | Clear the core's delay-slot flag |
| pend_idx | output | 5 | Pending index, all ones when none |

## Verification
A wrong class decode or delay-slot selection shows up as a wrong `epc_o` in the `done` cycle that answers the request, one edge after acceptance. Status-building errors show up in the same cycle as single flipped bits of `sr_o`. A stuck pulse or stuck index register shows up one cycle later: `done`, `tlb_flush` or `req_ready` fails to return, or `pend_idx` fails to go back to all ones. A request held across the result cycle exposes any handshake flaw as a missing or duplicated result.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic {
    CLS_REEXEC = 1'b0,
    CLS_RESUME = 1'b1
  } exc_class_e;
endpackage

// File: rtl/exc_class_dec.sv
module exc_class_dec
  import exc_entry_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int N_RESUME = 4,
  parameter logic [N_RESUME*IDX_W-1:0] RESUME_SET = {5'd13, 5'd12, 5'd8, 5'd5}
) (
  input  logic [IDX_W-1:0] idx,
  output exc_class_e       cls
);
  logic [N_RESUME-1:0] hit;

  for (genvar g = 0; g < N_RESUME; g++) begin : g_match
    assign hit[g] = (idx == RESUME_SET[g*IDX_W +: IDX_W]);
  end

  assign cls = (|hit) ? CLS_RESUME : CLS_REEXEC;
endmodule

// File: rtl/exc_epc_sel.sv
module exc_epc_sel
  import exc_entry_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  exc_class_e      cls,
  input  logic            dslot,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] npc,
  input  logic [PC_W-1:0] jmp_pc,
  output logic [PC_W-1:0] epc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_comb begin
    unique case ({dslot, cls})
      {1'b1, CLS_RESUME}: epc = jmp_pc;
      {1'b1, CLS_REEXEC}: epc = pc - STEP;
      {1'b0, CLS_RESUME}: epc = npc;
      default:            epc = pc;
    endcase
  end
endmodule

// File: rtl/exc_sr_build.sv
module exc_sr_build #(
  parameter int SR_W    = 32,
  parameter int SM_BIT  = 0,
  parameter int TEE_BIT = 1,
  parameter int IEE_BIT = 2,
  parameter int DME_BIT = 5,
  parameter int IME_BIT = 6,
  parameter int DSX_BIT = 13
) (
  input  logic [SR_W-1:0] sr_in,
  input  logic            dslot,
  output logic [SR_W-1:0] sr_out
);
  localparam logic [SR_W-1:0] CLR_MASK = (SR_W'(1) << TEE_BIT) | (SR_W'(1) << IEE_BIT)
                                        | (SR_W'(1) << DME_BIT) | (SR_W'(1) << IME_BIT);
  localparam logic [SR_W-1:0] SET_MASK = SR_W'(1) << SM_BIT;
  localparam logic [SR_W-1:0] DSX_MASK = SR_W'(1) << DSX_BIT;

  assign sr_out = (sr_in & ~CLR_MASK) | SET_MASK | (dslot ? DSX_MASK : '0);
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 5,
  parameter int NUM_EXC   = 15,
  parameter int VEC_SHIFT = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [PC_W-1:0]  vec,
  output logic             take,
  output logic             bad
);
  localparam int PAD = PC_W - IDX_W - VEC_SHIFT;

  always_comb begin
    take = (idx != '0) && (int'(idx) < NUM_EXC);
    bad  = !take;
    vec  = take ? {{PAD{1'b0}}, idx, {VEC_SHIFT{1'b0}}} : '0;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SR_W       = 32,
  parameter int IDX_W      = 5,
  parameter int NUM_EXC    = 15,
  parameter int VEC_SHIFT  = 8,
  parameter int INSN_BYTES = 4,
  parameter int N_RESUME   = 4,
  parameter logic [N_RESUME*IDX_W-1:0] RESUME_SET = {5'd13, 5'd12, 5'd8, 5'd5},
  parameter int SM_BIT     = 0,
  parameter int TEE_BIT    = 1,
  parameter int IEE_BIT    = 2,
  parameter int DME_BIT    = 5,
  parameter int IME_BIT    = 6,
  parameter int DSX_BIT    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [PC_W-1:0]  req_npc,
  input  logic [PC_W-1:0]  req_jmp_pc,
  input  logic             req_dslot,
  input  logic [SR_W-1:0]  req_sr,
  output logic             done,
  output logic [PC_W-1:0]  epc_o,
  output logic [SR_W-1:0]  esr_o,
  output logic [SR_W-1:0]  sr_o,
  output logic [PC_W-1:0]  vec_pc_o,
  output logic             vec_take,
  output logic             abort,
  output logic             tlb_flush,
  output logic             xlate_off,
  output logic             dslot_clr,
  output logic [IDX_W-1:0] pend_idx
);
  exc_class_e       cls;
  logic [PC_W-1:0]  epc_nx;
  logic [SR_W-1:0]  sr_nx;
  logic [PC_W-1:0]  vec_nx;
  logic             take_nx;
  logic             bad_nx;
  logic             accept;

  assign req_ready = !done;
  assign accept    = req_valid && req_ready;

  exc_class_dec #(.IDX_W(IDX_W), .N_RESUME(N_RESUME), .RESUME_SET(RESUME_SET)) u_cls (
    .idx(req_idx), .cls(cls)
  );

  exc_epc_sel #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_epc (
    .cls(cls), .dslot(req_dslot), .pc(req_pc), .npc(req_npc),
    .jmp_pc(req_jmp_pc), .epc(epc_nx)
  );

  exc_sr_build #(
    .SR_W(SR_W), .SM_BIT(SM_BIT), .TEE_BIT(TEE_BIT), .IEE_BIT(IEE_BIT),
    .DME_BIT(DME_BIT), .IME_BIT(IME_BIT), .DSX_BIT(DSX_BIT)
  ) u_sr (
    .sr_in(req_sr), .dslot(req_dslot), .sr_out(sr_nx)
  );

  exc_vec_gen #(.PC_W(PC_W), .IDX_W(IDX_W), .NUM_EXC(NUM_EXC), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .idx(req_idx), .vec(vec_nx), .take(take_nx), .bad(bad_nx)
  );

  // Pulses: high only in the cycle after an accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      tlb_flush <= 1'b0;
      xlate_off <= 1'b0;
      dslot_clr <= 1'b0;
      vec_take  <= 1'b0;
      abort     <= 1'b0;
    end else begin
      done      <= accept;
      tlb_flush <= accept;
      xlate_off <= accept;
      dslot_clr <= accept && req_dslot;
      vec_take  <= accept && take_nx;
      abort     <= accept && bad_nx;
    end
  end

  // Data results hold until the next accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o    <= '0;
      esr_o    <= '0;
      sr_o     <= '0;
      vec_pc_o <= '0;
    end else if (accept) begin
      epc_o    <= epc_nx;
      esr_o    <= req_sr;
      sr_o     <= sr_nx;
      vec_pc_o <= vec_nx;
    end
  end

  // Pending index: all ones means no exception pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_idx <= '1;
    else if (accept) pend_idx <= req_idx;
    else if (done)   pend_idx <= '1;
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int PC_W    = 32,
  parameter int SR_W    = 32,
  parameter int IDX_W   = 5,
  parameter int SM_BIT  = 0,
  parameter int TEE_BIT = 1,
  parameter int IEE_BIT = 2,
  parameter int DME_BIT = 5,
  parameter int IME_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SR_W-1:0]  req_sr,
  input logic             done,
  input logic [SR_W-1:0]  esr_o,
  input logic [SR_W-1:0]  sr_o,
  input logic [PC_W-1:0]  vec_pc_o,
  input logic             vec_take,
  input logic             abort,
  input logic             tlb_flush,
  input logic             xlate_off,
  input logic             dslot_clr,
  input logic [IDX_W-1:0] pend_idx
);
  a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_flush_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_flush == done) && (xlate_off == done));
  a_r7_busy_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r2_esr_copy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> esr_o == $past(req_sr));
  a_r3_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sr_o[SM_BIT] && !sr_o[TEE_BIT] && !sr_o[IEE_BIT] && !sr_o[DME_BIT] && !sr_o[IME_BIT]));
  a_r4_take_or_abort: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({vec_take, abort}));
  a_r5_abort_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> vec_pc_o == '0);
  a_r8_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend_idx == '1);
  a_r9_clr_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr |-> done);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .PC_W(PC_W), .SR_W(SR_W), .IDX_W(IDX_W), .SM_BIT(SM_BIT), .TEE_BIT(TEE_BIT),
  .IEE_BIT(IEE_BIT), .DME_BIT(DME_BIT), .IME_BIT(IME_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sr(req_sr), .done(done), .esr_o(esr_o), .sr_o(sr_o), .vec_pc_o(vec_pc_o),
  .vec_take(vec_take), .abort(abort), .tlb_flush(tlb_flush), .xlate_off(xlate_off),
  .dslot_clr(dslot_clr), .pend_idx(pend_idx)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_idx = '0;
  logic [31:0] req_pc = '0, req_npc = '0, req_jmp_pc = '0, req_sr = '0;
  logic        req_dslot = 1'b0;
  logic        done, vec_take, abort, tlb_flush, xlate_off, dslot_clr;
  logic [31:0] epc_o, esr_o, sr_o, vec_pc_o;
  logic [4:0]  pend_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_pc(req_pc), .req_npc(req_npc), .req_jmp_pc(req_jmp_pc),
    .req_dslot(req_dslot), .req_sr(req_sr), .done(done), .epc_o(epc_o),
    .esr_o(esr_o), .sr_o(sr_o), .vec_pc_o(vec_pc_o), .vec_take(vec_take),
    .abort(abort), .tlb_flush(tlb_flush), .xlate_off(xlate_off),
    .dslot_clr(dslot_clr), .pend_idx(pend_idx)
  );

  typedef struct packed {
    logic [4:0]  idx;
    logic        ds;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [31:0] jmp;
    logic [31:0] sr;
    logic [31:0] exp_epc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{5'd5,  1'b0, 32'h0000_1000, 32'h0000_1004, 32'h0000_2000, 32'h0000_8067, 32'h0000_1004},
    '{5'd2,  1'b0, 32'h0000_1100, 32'h0000_1104, 32'h0000_2100, 32'h0000_0000, 32'h0000_1100},
    '{5'd8,  1'b1, 32'h0000_3008, 32'h0000_300C, 32'h0000_4440, 32'hFFFF_FFFF, 32'h0000_4440},
    '{5'd9,  1'b1, 32'h0000_500C, 32'h0000_5010, 32'h0000_6000, 32'h1234_5678, 32'h0000_5008},
    '{5'd12, 1'b0, 32'h0000_7000, 32'h0000_7004, 32'h0000_7100, 32'h0000_2067, 32'h0000_7004},
    '{5'd13, 1'b1, 32'h0000_8004, 32'h0000_8008, 32'h0000_9ABC, 32'hA5A5_A5A5, 32'h0000_9ABC},
    '{5'd14, 1'b0, 32'h0000_A000, 32'h0000_A004, 32'h0000_B000, 32'h0000_0001, 32'h0000_A000},
    '{5'd1,  1'b1, 32'h0000_C010, 32'h0000_C014, 32'h0000_D000, 32'h8000_0040, 32'h0000_C00C}
  };

  function automatic logic [31:0] exp_sr(logic [31:0] s, logic ds);
    return (s & ~32'h0000_0066) | 32'h1 | (ds ? 32'h0000_2000 : 32'h0);
  endfunction

  function automatic logic [31:0] exp_vec(logic [4:0] i);
    return (i != 0 && i < 15) ? {19'd0, i, 8'd0} : 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] i, logic ds, logic [31:0] pc, logic [31:0] npc,
                       logic [31:0] jmp, logic [31:0] sr);
    req_idx = i; req_dslot = ds; req_pc = pc; req_npc = npc; req_jmp_pc = jmp; req_sr = sr;
  endtask

  // Offers one request and leaves the clock at the negedge where done is high.
  task automatic send(logic [4:0] i, logic ds, logic [31:0] pc, logic [31:0] npc,
                      logic [31:0] jmp, logic [31:0] sr);
    @(negedge clk);
    drive(i, ds, pc, npc, jmp, sr);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_result(logic [4:0] i, logic ds, logic [31:0] sr, logic [31:0] epc);
    logic ok;
    ok = (i != 0 && i < 15);
    chk("R6 done", {31'd0, done}, 32'd1);
    chk("R6 tlb_flush/xlate_off", {30'd0, tlb_flush, xlate_off}, 32'd3);
    chk("R1 epc", epc_o, epc);
    chk("R2 esr", esr_o, sr);
    chk("R3 sr", sr_o, exp_sr(sr, ds));
    chk("R4 vec_pc", vec_pc_o, exp_vec(i));
    chk("R4/R5 take,abort", {30'd0, vec_take, abort}, {30'd0, ok, !ok});
    chk("R9 dslot_clr", {31'd0, dslot_clr}, {31'd0, ds});
    chk("R8 pend_idx in done", {27'd0, pend_idx}, {27'd0, i});
    chk("R7 ready low in done", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R6 pulses drop", {28'd0, done, tlb_flush, xlate_off, dslot_clr}, 32'd0);
    chk("R8 pend_idx none", {27'd0, pend_idx}, 32'h1F);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pulses in reset", {26'd0, done, tlb_flush, xlate_off, dslot_clr, vec_take, abort}, 32'd0);
    chk("R10 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R10 epc/sr zero", epc_o | esr_o | sr_o | vec_pc_o, 32'd0);
    chk("R8 pend_idx after reset", {27'd0, pend_idx}, 32'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {31'd0, done}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      send(TBL[k].idx, TBL[k].ds, TBL[k].pc, TBL[k].npc, TBL[k].jmp, TBL[k].sr);
      check_result(TBL[k].idx, TBL[k].ds, TBL[k].sr, TBL[k].exp_epc);
    end

    // R5: indices without a vector
    send(5'd0, 1'b0, 32'h100, 32'h104, 32'h200, 32'h0000_0066);
    check_result(5'd0, 1'b0, 32'h0000_0066, 32'h100);
    send(5'd15, 1'b1, 32'h300, 32'h304, 32'h400, 32'h0);
    check_result(5'd15, 1'b1, 32'h0, 32'h2FC);
    send(5'd31, 1'b0, 32'h500, 32'h504, 32'h600, 32'hFFFF_FFFF);
    check_result(5'd31, 1'b0, 32'hFFFF_FFFF, 32'h500);

    // R1 wrap: re-execute in a delay slot at PC zero
    send(5'd3, 1'b1, 32'h0, 32'h4, 32'h800, 32'h0);
    check_result(5'd3, 1'b1, 32'h0, 32'hFFFF_FFFC);

    // R7: request held across the done cycle is not taken twice
    @(negedge clk);
    drive(5'd4, 1'b0, 32'hE000, 32'hE004, 32'hF000, 32'h0);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R7 first accept", {31'd0, done}, 32'd1);
    chk("R7 ready low", {31'd0, req_ready}, 32'd0);
    drive(5'd6, 1'b1, 32'h1230, 32'h1234, 32'h5550, 32'h0);
    @(negedge clk);
    chk("R7 ignored in done cycle", {31'd0, done}, 32'd0);
    chk("R7 epc unchanged", epc_o, 32'hE000);
    chk("R7 vec unchanged", vec_pc_o, 32'h400);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 taken next cycle", {31'd0, done}, 32'd1);
    chk("R7 new epc", epc_o, 32'h122C);
    chk("R7 new vec", vec_pc_o, 32'h600);
    @(negedge clk);
    chk("R7 no repeat", {31'd0, done}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R6 idle without request", {29'd0, done, tlb_flush, xlate_off}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule